// File: doc/BRIEF.md
# USB 1.x Host Controller Register File

This block is the software-visible register file of a USB 1.x host controller. A simple I/O bus presents a byte offset, an access size, a read strobe, a write strobe and write data. The block decodes the offset into one of six registers: command, status, interrupt enable, frame number, frame list base address and start-of-frame adjust. Reads return data combinationally in the same cycle as the read strobe.

A 1 ms tick input advances a 10-bit frame counter. The same tick sets the halted status bit whenever the run bit is clear. It also paces a global port reset that software starts from the command register. The block drives three outputs: the halted flag, a port-reset signal for the port logic, and a one-cycle flag for accesses whose size does not match the register they address. Schedule traversal, DMA, packet handling and interrupt generation belong to other blocks.

Top module: `usb_hc_regs`

## Requirements
- R1: After the synchronous active-low reset, the registers read as follows: command 0x0008 (only global suspend, bit 3, set), status 0, interrupt enable 0, frame number 0, frame base 0 and start-of-frame adjust 0x40. The halted, port_reset and size_err outputs are 0.
- R2: The access size is encoded as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = invalid. The command register sits at offset 0x00 and takes 2-byte accesses. Bits 7:0 are read/write: bit 7 max packet, 6 configured, 5 debug, 4 global resume, 3 global suspend, 2 global reset, 1 host reset, 0 run. Bits 15:8 read 0.
- R3: The status register sits at offset 0x02 and takes 2-byte accesses. Bit 5 is halted. Writing 1 to a status bit clears it and writing 0 leaves it unchanged. Bits with no set source read 0.
- R4: The interrupt enable register sits at offset 0x04 and takes 2-byte accesses. Bits 3:0 are read/write and bits 15:4 read 0.
- R5: The frame number sits at offset 0x06 and takes 2-byte accesses. It reads in bits 9:0 and increments by one on each tick, wrapping from 1023 to 0.
- R6: A frame number write (bits 9:0) is applied only while halted is 1 and is otherwise ignored. An applied write takes priority over a tick in the same cycle.
- R7: A tick in a cycle where the run bit is 0 sets halted. If a write-one-to-clear of halted lands in the same cycle, the set wins. The halted output mirrors status bit 5.
- R8: A command write with bit 2 set loads a counter with 10. On each tick the counter behaves as follows: while it is nonzero, port_reset is driven to 1 and the counter decrements; once it is zero, port_reset is driven to 0. As a result, port_reset stays high from the first tick through the tenth and falls on the eleventh.
- R9: A command write with bit 1 set returns every register, the global reset counter and port_reset to their reset values. This takes priority over all other effects in that cycle.
- R10: The frame base sits at offset 0x08 and takes 4-byte accesses. Bits 31:12 are stored and bits 11:0 always read 0.
- R11: The start-of-frame adjust register sits at offset 0x0C and takes 1-byte accesses. Bits 6:0 are stored and bit 7 always reads 0.
- R12: A read or write to a mapped offset with the wrong size changes no state, reads as 0, and pulses size_err in the following cycle.
- R13: Offsets that map to no register read 0, ignore writes and never raise size_err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte offset of the access |
| bus_size | input | 2 | Access size code (R2) |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| tick_1ms | input | 1 | One-cycle frame tick |
| halted | output | 1 | Controller halted flag |
| port_reset | output | 1 | Global reset drive to all ports |
| size_err | output | 1 | One-cycle pulse after a wrongly sized access |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:
- The frame counter wrapping from 1023. A counter of the wrong width would read 1024 or saturate.
- A frame number write while the controller is running. A design without the halt gate would load the value.
- A status write with ones in bits other than halted. This catches decoding that clears the wrong bit.
- The eleventh tick after a global reset request, where an off-by-one counter would release port_reset early or late.
- A host reset issued together with other command bits. A priority bug would leave some register at its written value.
- Wrongly sized accesses to every register. These should produce the error pulse with no state change, and would expose a size check applied after the write instead of before it.

// File: rtl/usb_hc_pkg.sv
// Package: shared encodings for the USB host controller register file.
// Assumes byte offsets fit in ADDR_W bits.
package usb_hc_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;

    // Access size code on the bus
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_BAD   = 2'd3
    } acc_size_e;

    // Register selected by the offset decoder
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CMD,
        SEL_STS,
        SEL_IEN,
        SEL_FNUM,
        SEL_FBASE,
        SEL_SOF
    } reg_sel_e;

    localparam logic [ADDR_W-1:0] OFS_CMD   = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_STS   = 5'h02;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_FNUM  = 5'h06;
    localparam logic [ADDR_W-1:0] OFS_FBASE = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_SOF   = 5'h0C;

    // Command register bit positions
    localparam int CMD_RUN  = 0;
    localparam int CMD_HRST = 1;
    localparam int CMD_GRST = 2;
    localparam int STS_HALT = 5;

endpackage

// File: rtl/usb_hc_decode.sv
// Module: offset and size decoder.
// Maps a byte offset to a register select and reports whether the
// access size matches that register's width. Purely combinational.
module usb_hc_decode
    import usb_hc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output reg_sel_e          sel,
    output logic              size_ok
);

    acc_size_e need;

    // Select the register and the size it requires
    always_comb begin
        sel  = SEL_NONE;
        need = SZ_BAD;
        case (addr)
            OFS_CMD:   begin sel = SEL_CMD;   need = SZ_WORD;  end
            OFS_STS:   begin sel = SEL_STS;   need = SZ_WORD;  end
            OFS_IEN:   begin sel = SEL_IEN;   need = SZ_WORD;  end
            OFS_FNUM:  begin sel = SEL_FNUM;  need = SZ_WORD;  end
            OFS_FBASE: begin sel = SEL_FBASE; need = SZ_DWORD; end
            OFS_SOF:   begin sel = SEL_SOF;   need = SZ_BYTE;  end
            default:   begin sel = SEL_NONE;  need = SZ_BAD;   end
        endcase
    end

    // Size is acceptable only on a mapped register with a matching width
    assign size_ok = (sel != SEL_NONE) && (size == need);

endmodule

// File: rtl/usb_hc_frame.sv
// Module: frame counter and global port reset sequencer.
// Counts ticks modulo 2**FNUM_W and holds port reset for GRST_FRAMES
// ticks after a load. Assumes tick is a one-cycle pulse.
module usb_hc_frame #(
    parameter int FNUM_W      = 10,
    parameter int GRST_FRAMES = 10,
    localparam int CNT_W      = $clog2(GRST_FRAMES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              tick,
    input  logic              fn_wr_en,
    input  logic [FNUM_W-1:0] fn_wdata,
    input  logic              grst_load,
    output logic [FNUM_W-1:0] frame_num,
    output logic              port_reset,
    output logic [CNT_W-1:0]  grst_cnt
);

    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(GRST_FRAMES);

    // Frame number: software load beats tick increment
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            frame_num <= '0;
        else if (fn_wr_en)
            frame_num <= fn_wdata;
        else if (tick)
            frame_num <= frame_num + 1'b1;
    end

    // Reset sequencer counter: load beats tick decrement
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            grst_cnt <= '0;
        else if (grst_load)
            grst_cnt <= LOAD_VAL;
        else if (tick && grst_cnt != '0)
            grst_cnt <= grst_cnt - 1'b1;
    end

    // Port reset drive updated once per tick
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            port_reset <= 1'b0;
        else if (tick)
            port_reset <= (grst_cnt != '0);
    end

endmodule

// File: rtl/usb_hc_regs.sv
// Module: USB host controller register file (top).
// Holds command, status, interrupt enable, frame base and SOF adjust
// registers; frame counter and reset sequencer live in usb_hc_frame.
// Assumes one access per cycle and a single-cycle tick.
module usb_hc_regs
    import usb_hc_pkg::*;
#(
    parameter int FNUM_W      = 10,
    parameter int GRST_FRAMES = 10,
    parameter int SOF_W       = 7,
    parameter logic [SOF_W-1:0] SOF_RESET = 7'h40,
    parameter int BASE_LSB    = 12,
    localparam int CNT_W      = $clog2(GRST_FRAMES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_1ms,
    output logic              halted,
    output logic              port_reset,
    output logic              size_err
);

    localparam logic [7:0] CMD_RESET = 8'h08;

    reg_sel_e                   sel;
    logic                       size_ok;
    logic                       wr_ok;
    logic                       host_rst;
    logic [7:0]                 cmd_q;
    logic                       halt_q;
    logic [3:0]                 ien_q;
    logic [DATA_W-1:BASE_LSB]   fbase_q;
    logic [SOF_W-1:0]           sof_q;
    logic [FNUM_W-1:0]          fnum;
    logic [CNT_W-1:0]           grst_cnt;
    logic                       unused_wdata;

    assign unused_wdata = ^bus_wdata[BASE_LSB-1:FNUM_W];

    usb_hc_decode i_decode (
        .addr    (bus_addr),
        .size    (bus_size),
        .sel     (sel),
        .size_ok (size_ok)
    );

    assign wr_ok    = bus_wr && size_ok;
    assign host_rst = wr_ok && (sel == SEL_CMD) && bus_wdata[CMD_HRST];

    usb_hc_frame #(
        .FNUM_W      (FNUM_W),
        .GRST_FRAMES (GRST_FRAMES)
    ) i_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (host_rst),
        .tick       (tick_1ms),
        .fn_wr_en   (wr_ok && (sel == SEL_FNUM) && halt_q),
        .fn_wdata   (bus_wdata[FNUM_W-1:0]),
        .grst_load  (wr_ok && (sel == SEL_CMD) && bus_wdata[CMD_GRST]),
        .frame_num  (fnum),
        .port_reset (port_reset),
        .grst_cnt   (grst_cnt)
    );

    // Command, interrupt enable, frame base and SOF adjust storage
    always_ff @(posedge clk) begin
        if (!rst_n || host_rst) begin
            cmd_q   <= CMD_RESET;
            ien_q   <= '0;
            fbase_q <= '0;
            sof_q   <= SOF_RESET;
        end else if (wr_ok) begin
            case (sel)
                SEL_CMD:   cmd_q   <= bus_wdata[7:0];
                SEL_IEN:   ien_q   <= bus_wdata[3:0];
                SEL_FBASE: fbase_q <= bus_wdata[DATA_W-1:BASE_LSB];
                SEL_SOF:   sof_q   <= bus_wdata[SOF_W-1:0];
                default:   ;
            endcase
        end
    end

    // Halted status: tick with run clear sets it, write-one clears it
    always_ff @(posedge clk) begin
        if (!rst_n || host_rst)
            halt_q <= 1'b0;
        else if (tick_1ms && !cmd_q[CMD_RUN])
            halt_q <= 1'b1;
        else if (wr_ok && (sel == SEL_STS) && bus_wdata[STS_HALT])
            halt_q <= 1'b0;
    end

    // Size error pulse for mapped accesses of the wrong width
    always_ff @(posedge clk) begin
        if (!rst_n)
            size_err <= 1'b0;
        else
            size_err <= (bus_rd || bus_wr) && (sel != SEL_NONE) && !size_ok;
    end

    // Read data mux, zero unless a correctly sized read is in progress
    always_comb begin
        bus_rdata = '0;
        if (bus_rd && size_ok) begin
            case (sel)
                SEL_CMD:   bus_rdata[7:0]               = cmd_q;
                SEL_STS:   bus_rdata[STS_HALT]          = halt_q;
                SEL_IEN:   bus_rdata[3:0]               = ien_q;
                SEL_FNUM:  bus_rdata[FNUM_W-1:0]        = fnum;
                SEL_FBASE: bus_rdata[DATA_W-1:BASE_LSB] = fbase_q;
                SEL_SOF:   bus_rdata[SOF_W-1:0]         = sof_q;
                default:   ;
            endcase
        end
    end

    assign halted = halt_q;

endmodule

// File: rtl/usb_hc_regs_chk.sv
// Module: property checker for usb_hc_regs, attached by bind.
// Observes ports plus the frame counter, command and sequencer count.
module usb_hc_regs_chk
    import usb_hc_pkg::*;
#(
    parameter int FNUM_W = 10,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              tick_1ms,
    input logic              halted,
    input logic              port_reset,
    input logic              size_err,
    input logic [7:0]        cmd_q,
    input logic [FNUM_W-1:0] fnum,
    input logic [CNT_W-1:0]  grst_cnt
);

    logic hrst_req;
    logic fn_touch;
    assign hrst_req = bus_wr && bus_addr == OFS_CMD && bus_size == 2'd1 && bus_wdata[CMD_HRST];
    assign fn_touch = bus_wr && bus_addr == OFS_FNUM;

    AST_FNUM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1ms && fnum == '1 && !fn_touch && !hrst_req) |=> (fnum == '0)); // R5

    AST_FNUM_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_touch && !halted && !tick_1ms) |=> $stable(fnum)); // R6

    AST_HALT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1ms && !cmd_q[CMD_RUN] && !hrst_req) |=> halted); // R7

    AST_PORT_RESET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1ms && grst_cnt != '0 && !hrst_req) |=> port_reset); // R8

    AST_PORT_RESET_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1ms && grst_cnt == '0) |=> !port_reset); // R8

    AST_SIZE_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && bus_addr == OFS_SOF && bus_size != 2'd0) |=> size_err); // R12

endmodule

bind usb_hc_regs usb_hc_regs_chk #(
    .FNUM_W (FNUM_W),
    .CNT_W  (CNT_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_size   (bus_size),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .tick_1ms   (tick_1ms),
    .halted     (halted),
    .port_reset (port_reset),
    .size_err   (size_err),
    .cmd_q      (cmd_q),
    .fnum       (fnum),
    .grst_cnt   (grst_cnt)
);

// File: tb/test_usb_hc_regs.sv
// Bench: directed corner cases followed by seeded random traffic,
// compared against a behavioural model built from the requirements.
module test_usb_hc_regs;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_1ms = 1'b0;
    logic        halted;
    logic        port_reset;
    logic        size_err;

    int n_chk = 0;
    int n_fail = 0;

    // behavioural model state
    logic [7:0]  m_cmd;
    logic        m_halt;
    logic [3:0]  m_ien;
    logic [9:0]  m_fn;
    logic [19:0] m_fb;
    logic [6:0]  m_sof;
    int          m_cnt;
    logic        m_prst;
    logic        m_serr;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_hc_regs i_usb_hc_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_size   (bus_size),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .tick_1ms   (tick_1ms),
        .halted     (halted),
        .port_reset (port_reset),
        .size_err   (size_err)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        summary();
        $finish;
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic int need_size(input logic [4:0] a);
        case (a)
            5'h00, 5'h02, 5'h04, 5'h06: return 1;
            5'h08:                      return 2;
            5'h0C:                      return 0;
            default:                    return -1;
        endcase
    endfunction

    function automatic string req_of(input logic [4:0] a, input logic [1:0] sz);
        if (need_size(a) < 0) return "R13";
        if (int'(sz) != need_size(a)) return "R12";
        case (a)
            5'h00:   return "R2";
            5'h02:   return "R3";
            5'h04:   return "R4";
            5'h06:   return "R5";
            5'h08:   return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input logic [4:0] a, input logic [1:0] sz);
        if (need_size(a) < 0 || int'(sz) != need_size(a)) return 32'h0;
        case (a)
            5'h00:   return {24'h0, m_cmd};
            5'h02:   return {26'h0, m_halt, 5'h0};
            5'h04:   return {28'h0, m_ien};
            5'h06:   return {22'h0, m_fn};
            5'h08:   return {m_fb, 12'h0};
            default: return {25'h0, m_sof};
        endcase
    endfunction

    task automatic model_reset();
        m_cmd = 8'h08; m_halt = 1'b0; m_ien = '0; m_fn = '0;
        m_fb = '0; m_sof = 7'h40; m_cnt = 0; m_prst = 1'b0;
    endtask

    // Advance the model across one clock edge, from the requirements
    task automatic model_step(input logic rd, input logic wr, input logic [4:0] a,
                              input logic [1:0] sz, input logic [31:0] d, input logic tk);
        bit   mapped = need_size(a) >= 0;
        bit   ok = mapped && int'(sz) == need_size(a);
        bit   wok = wr && ok;
        logic [9:0] n_fn;
        logic n_halt;
        int   n_cnt;
        logic n_prst;
        m_serr = (rd || wr) && mapped && !ok;
        if (wok && a == 5'h00 && d[1]) begin
            model_reset();
            return;
        end
        n_fn = tk ? m_fn + 10'd1 : m_fn;
        if (wok && a == 5'h06 && m_halt) n_fn = d[9:0];
        n_halt = m_halt;
        if (wok && a == 5'h02 && d[5]) n_halt = 1'b0;
        if (tk && !m_cmd[0]) n_halt = 1'b1;
        n_cnt = m_cnt;
        n_prst = m_prst;
        if (tk) begin
            if (m_cnt > 0) begin n_prst = 1'b1; n_cnt = m_cnt - 1; end
            else n_prst = 1'b0;
        end
        if (wok && a == 5'h00 && d[2]) n_cnt = 10;
        if (wok && a == 5'h00) m_cmd = d[7:0];
        if (wok && a == 5'h04) m_ien = d[3:0];
        if (wok && a == 5'h08) m_fb = d[31:12];
        if (wok && a == 5'h0C) m_sof = d[6:0];
        m_fn = n_fn; m_halt = n_halt; m_cnt = n_cnt; m_prst = n_prst;
    endtask

    // One bus cycle: drive at negedge, check read data, check outputs after edge
    task automatic step(input logic rd, input logic wr, input logic [4:0] a,
                        input logic [1:0] sz, input logic [31:0] d, input logic tk,
                        input string tag = "");
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_size = sz;
        bus_wdata = d; tick_1ms = tk;
        #1;
        if (rd) chk(bus_rdata, exp_read(a, sz), (tag != "") ? tag : req_of(a, sz));
        @(posedge clk);
        model_step(rd, wr, a, sz, d, tk);
        #1;
        bus_rd = 1'b0; bus_wr = 1'b0; tick_1ms = 1'b0;
        chk({31'h0, halted},     {31'h0, m_halt}, "R7");
        chk({31'h0, port_reset}, {31'h0, m_prst}, "R8");
        chk({31'h0, size_err},   {31'h0, m_serr}, "R12");
    endtask

    task automatic rd_reg(input logic [4:0] a, input logic [1:0] sz, input string tag = "");
        step(1'b1, 1'b0, a, sz, 32'h0, 1'b0, tag);
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [1:0] sz, input logic [31:0] d,
                          input logic tk = 1'b0);
        step(1'b0, 1'b1, a, sz, d, tk);
    endtask

    task automatic tick_only();
        step(1'b0, 1'b0, 5'h00, 2'd1, 32'h0, 1'b1);
    endtask

    task automatic read_all(input string tag);
        rd_reg(5'h00, 2'd1, tag);
        rd_reg(5'h02, 2'd1, tag);
        rd_reg(5'h04, 2'd1, tag);
        rd_reg(5'h06, 2'd1, tag);
        rd_reg(5'h08, 2'd2, tag);
        rd_reg(5'h0C, 2'd0, tag);
    endtask

    initial begin
        logic [4:0] addrs [8];
        addrs = '{5'h00, 5'h02, 5'h04, 5'h06, 5'h08, 5'h0C, 5'h14, 5'h0A};
        void'($urandom(32'd20240611));
        model_reset();
        m_serr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values on every register and output
        read_all("R1");

        // R2: upper command bits are dropped, lower bits stored
        wr_reg(5'h00, 2'd1, 32'h0000_FFF1);
        rd_reg(5'h00, 2'd1, "R2");
        // R7: run cleared, tick sets halted
        wr_reg(5'h00, 2'd1, 32'h0000_0080);
        tick_only();
        // R3: zeros and other ones leave halted, bit 5 clears it
        wr_reg(5'h02, 2'd1, 32'h0000_FFDF);
        rd_reg(5'h02, 2'd1, "R3");
        // R7: set wins over clear in the same cycle
        wr_reg(5'h02, 2'd1, 32'h0000_0020, 1'b1);
        rd_reg(5'h02, 2'd1, "R7");
        // R5, R6: load 1023 while halted, tick wraps to 0
        wr_reg(5'h06, 2'd1, 32'h0000_03FF);
        rd_reg(5'h06, 2'd1, "R6");
        tick_only();
        rd_reg(5'h06, 2'd1, "R5");
        // R6: write beats tick in the same cycle
        wr_reg(5'h06, 2'd1, 32'h0000_0123, 1'b1);
        rd_reg(5'h06, 2'd1, "R6");
        // R6: running and not halted, write ignored
        wr_reg(5'h00, 2'd1, 32'h0000_0001);
        wr_reg(5'h02, 2'd1, 32'h0000_0020);
        wr_reg(5'h06, 2'd1, 32'h0000_0055);
        rd_reg(5'h06, 2'd1, "R6");
        // R8: global reset over eleven ticks
        wr_reg(5'h00, 2'd1, 32'h0000_0005);
        for (int i = 0; i < 12; i++) tick_only();
        // R4: interrupt enable width
        wr_reg(5'h04, 2'd1, 32'h0000_FFFF);
        rd_reg(5'h04, 2'd1, "R4");
        // R10: frame base alignment
        wr_reg(5'h08, 2'd2, 32'hFFFF_FFFF);
        rd_reg(5'h08, 2'd2, "R10");
        // R11: SOF bit 7 reads zero
        wr_reg(5'h0C, 2'd0, 32'h0000_00FF);
        rd_reg(5'h0C, 2'd0, "R11");
        // R12: wrongly sized accesses change nothing and read zero
        wr_reg(5'h02, 2'd0, 32'h0000_0000);
        wr_reg(5'h04, 2'd2, 32'h0000_0000);
        wr_reg(5'h0C, 2'd1, 32'h0000_0000);
        rd_reg(5'h00, 2'd2, "R12");
        rd_reg(5'h04, 2'd1, "R12");
        // R13: unmapped offsets
        wr_reg(5'h14, 2'd1, 32'hFFFF_FFFF);
        rd_reg(5'h14, 2'd1, "R13");
        // R9: host reset with other bits set restores everything
        wr_reg(5'h00, 2'd1, 32'h0000_0005);
        tick_only();
        wr_reg(5'h00, 2'd1, 32'h0000_00F7, 1'b1);
        read_all("R9");

        // Random traffic
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [4:0]  a = addrs[$urandom_range(7)];
            int          ns = need_size(a);
            logic [1:0]  sz = ($urandom_range(99) < 85 && ns >= 0) ? 2'(ns) : 2'($urandom_range(3));
            logic [31:0] d = $urandom;
            logic        tk = ($urandom_range(99) < 30);
            int          kind = $urandom_range(2);
            if (a == 5'h00) begin
                d[1] = ($urandom_range(99) < 5);
                d[2] = ($urandom_range(99) < 10);
            end
            if (a == 5'h06 && $urandom_range(3) == 0) d[9:0] = 10'h3FF;
            step(kind == 0, kind == 1, a, sz, d, tk);
        end

        summary();
        $finish;
    end

endmodule